// File: doc/BRIEF.md
# Multi-Port Packet Bus Transmit Sink

This block sits on the port side of a 32-bit packet transmit bus that is shared by four ports. It runs on the bus's transmit clock and examines every cycle. When the active-low enable is high and the start-of-transfer strobe is raised, the cycle is a port-select cycle. The low two data bits name the port that receives the words that follow. When the enable is low, the cycle carries one packet double word. That word goes to the selected port's output stream one cycle later. It carries a byte-valid mask and start and end flags.

The block also answers packet-available polling. A two-bit poll address names a port, and one cycle later the shared status output shows whether that port's downstream space count can take at least one more burst. Per port, the block tracks whether a packet is open. It raises a one-cycle error pulse on that port when the framing rules are broken.

Top module: `pktbus_tx_sink`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `pkt_avail` are all zero, and the selected port is 0. A data word sent before any select cycle goes to port 0.
- R2: A cycle with `tx_en_n` = 0 is a data cycle. On the next cycle exactly one bit of `out_valid` is high: bit p, where p is the selected port. In that cycle `out_data`, `out_sop` and `out_eop` carry that word's `tx_data`, `tx_sop` and `tx_eop`.
- R3: A cycle with `tx_en_n` = 1 and `tx_sel` = 1 is a select cycle. It loads `tx_data[1:0]` as the new port and ignores `tx_data[31:2]`. It produces no output word.
- R4: While `tx_en_n` = 0, `tx_sel` has no effect. The word is forwarded to the current port as data, and the selection does not change.
- R5: The selected port holds across data and idle cycles until the next select cycle.
- R6: On a word with `tx_eop` = 1, `out_be` bit i marks byte `tx_data[8i+7:8i]` as valid. `tx_mod` counts missing bytes from the low end: 0 gives 4'b1111, 1 gives 4'b1110, 2 gives 4'b1100 and 3 gives 4'b1000.
- R7: On a word with `tx_eop` = 0, `out_be` is 4'b1111 whatever the value of `tx_mod`.
- R8: A data word with `tx_eop` = 0 and `tx_mod` nonzero raises `out_err[p]` for the selected port p. The pulse appears in the same cycle the word is forwarded and lasts one cycle.
- R9: Each port has its own open-packet state. A word with `tx_sop` = 1 on a port whose packet is still open raises `out_err[p]` in the forwarding cycle. An end-of-packet word closes the packet. A start-of-packet word without end-of-packet opens one. A single-word packet leaves the port closed.
- R10: `pkt_avail` is registered. In each cycle it shows whether port a has room for a burst, where a is the `poll_addr` value of the previous cycle. Port a's 4-bit space count sits at `port_space[4a+3:4a]`, and it has room when that count is at least BURST (default 8).
- R11: A cycle with `tx_en_n` = 1 and `tx_sel` = 0 is idle. It forwards nothing, raises no error and leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_n | input | 1 | Active-low transfer enable |
| tx_sel | input | 1 | Start-of-transfer strobe (port select when enable is high) |
| tx_mod | input | 2 | Count of missing low bytes on the end-of-packet word |
| tx_sop | input | 1 | Start of packet |
| tx_eop | input | 1 | End of packet |
| tx_data | input | 32 | Packet data or port number |
| poll_addr | input | 2 | Port whose availability is polled |
| port_space | input | 16 | Four 4-bit downstream space counts, port 0 in the low nibble |
| out_valid | output | 4 | One-hot word strobe per port |
| out_data | output | 32 | Forwarded word |
| out_be | output | 4 | Byte-valid mask of the forwarded word |
| out_sop | output | 1 | Start flag of the forwarded word |
| out_eop | output | 1 | End flag of the forwarded word |
| out_err | output | 4 | Per-port framing error pulse |
| pkt_avail | output | 1 | Packet-available status for the polled port |

## Verification
On every cycle, the in-RTL assertions check that at most one port strobe is high and that a strobe follows only a data cycle. They also check that select and idle cycles produce no word, that the selection changes only on a select cycle, and that non-final words carry a full mask. Error pulses must follow a word to that port, and a repeated start on an open packet must raise one. The bench's scenarios show the rest: that the in-band port number is decoded from the low data bits only, and that the modulo mapping is correct for each value. They also cover interleaved packets on different ports and the one-cycle poll latency against the space threshold.

// File: rtl/pktbus_pkg.sv
package pktbus_pkg;

    // Classification of one bus cycle
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_SEL  = 2'd1,
        CYC_WORD = 2'd2
    } cyc_kind_e;

    function automatic cyc_kind_e classify(input logic en_n, input logic sel);
        if (!en_n)
            return CYC_WORD;
        else if (sel)
            return CYC_SEL;
        else
            return CYC_IDLE;
    endfunction

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
    import pktbus_pkg::*;
#(
    parameter int DW = 32,
    parameter int NP = 4,
    parameter int NB = DW / 8,
    parameter int MW = $clog2(NB),
    parameter int PW = $clog2(NP)
) (
    input  logic          en_n,
    input  logic          sel,
    input  logic [MW-1:0] mod,
    input  logic          eop,
    input  logic [DW-1:0] data,
    output cyc_kind_e     kind,
    output logic [PW-1:0] port,
    output logic [NB-1:0] be,
    output logic          mod_bad
);

    always_comb begin
        kind    = classify(en_n, sel);
        port    = data[PW-1:0];
        mod_bad = !eop && (mod != '0);
    end

    // Byte i is valid unless it lies among the `mod` lowest bytes of a final word
    for (genvar i = 0; i < NB; i++) begin : g_be
        assign be[i] = eop ? (i >= int'(mod)) : 1'b1;
    end

endmodule

// File: rtl/pbr_port_track.sv
module pbr_port_track (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic sop,
    input  logic eop,
    input  logic mod_bad,
    output logic err
);

    typedef struct packed {
        logic open;
        logic err;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (hit) begin
            st_d.err = mod_bad || (sop && st_q.open);
            if (sop)
                st_d.open = !eop;
            else if (eop)
                st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign err = st_q.err;

    // R8
    err_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(hit));

    // R9
    resop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sop && st_q.open) |=> err);

endmodule

// File: rtl/pbr_poll.sv
module pbr_poll #(
    parameter int NP    = 4,
    parameter int SW    = 4,
    parameter int BURST = 8,
    parameter int PW    = $clog2(NP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    addr,
    input  logic [NP*SW-1:0] space,
    output logic             avail
);

    logic [NP-1:0] room;

    for (genvar p = 0; p < NP; p++) begin : g_room
        assign room[p] = space[p*SW +: SW] >= SW'(BURST);
    end

    typedef struct packed {
        logic avail;
    } poll_t;

    poll_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.avail = room[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign avail = st_q.avail;

endmodule

// File: rtl/pktbus_tx_sink.sv
module pktbus_tx_sink
    import pktbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NP    = 4,
    parameter int SW    = 4,
    parameter int BURST = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_en_n,
    input  logic                   tx_sel,
    input  logic [$clog2(DW/8)-1:0] tx_mod,
    input  logic                   tx_sop,
    input  logic                   tx_eop,
    input  logic [DW-1:0]          tx_data,
    input  logic [$clog2(NP)-1:0]  poll_addr,
    input  logic [NP*SW-1:0]       port_space,
    output logic [NP-1:0]          out_valid,
    output logic [DW-1:0]          out_data,
    output logic [DW/8-1:0]        out_be,
    output logic                   out_sop,
    output logic                   out_eop,
    output logic [NP-1:0]          out_err,
    output logic                   pkt_avail
);

    localparam int NB = DW / 8;
    localparam int MW = $clog2(NB);
    localparam int PW = $clog2(NP);

    cyc_kind_e     kind;
    logic [PW-1:0] dec_port;
    logic [NB-1:0] dec_be;
    logic          mod_bad;

    pbr_decode #(.DW(DW), .NP(NP), .NB(NB), .MW(MW), .PW(PW)) u_dec (
        .en_n    (tx_en_n),
        .sel     (tx_sel),
        .mod     (tx_mod),
        .eop     (tx_eop),
        .data    (tx_data),
        .kind    (kind),
        .port    (dec_port),
        .be      (dec_be),
        .mod_bad (mod_bad)
    );

    typedef struct packed {
        logic [PW-1:0] sel;
        logic [NP-1:0] vld;
        logic [DW-1:0] data;
        logic [NB-1:0] be;
        logic          sop;
        logic          eop;
    } top_t;

    top_t st_d, st_q;
    logic [NP-1:0] hit;

    always_comb begin
        st_d     = st_q;
        st_d.vld = '0;
        unique case (kind)
            CYC_SEL:  st_d.sel = dec_port;
            CYC_WORD: begin
                st_d.vld[st_q.sel] = 1'b1;
                st_d.data          = tx_data;
                st_d.be            = dec_be;
                st_d.sop           = tx_sop;
                st_d.eop           = tx_eop;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign hit[p] = (kind == CYC_WORD) && (st_q.sel == PW'(p));
        pbr_port_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[p]),
            .sop     (tx_sop),
            .eop     (tx_eop),
            .mod_bad (mod_bad),
            .err     (out_err[p])
        );
    end

    pbr_poll #(.NP(NP), .SW(SW), .BURST(BURST), .PW(PW)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (poll_addr),
        .space (port_space),
        .avail (pkt_avail)
    );

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_be    = st_q.be;
    assign out_sop   = st_q.sop;
    assign out_eop   = st_q.eop;

    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R2
    word_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> $past(!tx_en_n));

    // R11
    quiet_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n |=> (out_valid == '0));

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en_n && tx_sel) |=> $stable(st_q.sel));

    // R7
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && !out_eop) |-> (&out_be));

    // R6
    top_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && out_eop) |-> out_be[NB-1]);

endmodule

// File: tb/pktbus_tx_sink_test.sv
module pktbus_tx_sink_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_en_n, tx_sel, tx_sop, tx_eop;
    logic [1:0]  tx_mod, poll_addr;
    logic [31:0] tx_data;
    logic [15:0] port_space;
    logic [3:0]  out_valid, out_be, out_err;
    logic [31:0] out_data;
    logic        out_sop, out_eop, pkt_avail;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model
    logic [1:0]  m_sel;
    logic [3:0]  m_open;
    logic [3:0]  e_vld, e_be, e_err;
    logic [31:0] e_data;
    logic        e_sop, e_eop, e_avail;

    always #(CLK_PERIOD/2) clk = ~clk;

    pktbus_tx_sink uut (
        .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_sel(tx_sel),
        .tx_mod(tx_mod), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
        .poll_addr(poll_addr), .port_space(port_space),
        .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .pkt_avail(pkt_avail)
    );

    function automatic logic [3:0] exp_be(input logic eop, input logic [1:0] mod);
        logic [3:0] b;
        for (int i = 0; i < 4; i++) b[i] = !eop || (i >= int'(mod));
        return b;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, advance to the next negedge, compare
    task automatic step(input string tag, input logic en_n, input logic sel,
                        input logic [1:0] mod, input logic sop, input logic eop,
                        input logic [31:0] data, input logic [1:0] addr,
                        input logic [15:0] space);
        tx_en_n = en_n; tx_sel = sel; tx_mod = mod; tx_sop = sop; tx_eop = eop;
        tx_data = data; poll_addr = addr; port_space = space;
        e_vld = '0; e_err = '0;
        if (!en_n) begin
            e_vld        = 4'b1 << m_sel;
            e_data       = data;
            e_be         = exp_be(eop, mod);
            e_sop        = sop;
            e_eop        = eop;
            e_err        = 4'(((mod != 2'd0 && !eop) || (sop && m_open[m_sel])) ? 1 : 0) << m_sel;
            if (sop)      m_open[m_sel] = !eop;
            else if (eop) m_open[m_sel] = 1'b0;
        end else if (sel) begin
            m_sel = data[1:0];
        end
        e_avail = space[addr*4 +: 4] >= 4'd8;
        @(negedge clk);
        chk(out_valid == e_vld, {tag, " valid"}, 32'(out_valid), 32'(e_vld));
        if (e_vld != '0) begin
            chk(out_data == e_data, {tag, " data"}, out_data, e_data);
            chk(out_be == e_be, {tag, " be"}, 32'(out_be), 32'(e_be));
            chk({out_sop, out_eop} == {e_sop, e_eop}, {tag, " flags"},
                32'({out_sop, out_eop}), 32'({e_sop, e_eop}));
        end
        chk(out_err == e_err, {tag, " err"}, 32'(out_err), 32'(e_err));
        chk(pkt_avail == e_avail, {tag, " avail"}, 32'(pkt_avail), 32'(e_avail));
    endtask

    task automatic word(input string tag, input logic [1:0] mod, input logic sop,
                        input logic eop, input logic [31:0] data);
        step(tag, 1'b0, 1'b0, mod, sop, eop, data, 2'd0, 16'h0);
    endtask

    task automatic pick(input string tag, input logic [31:0] data);
        step(tag, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, data, 2'd0, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1104));
        rst_n = 1'b0; tx_en_n = 1'b1; tx_sel = 1'b0; tx_mod = '0; tx_sop = 1'b0;
        tx_eop = 1'b0; tx_data = '0; poll_addr = '0; port_space = 16'hFFFF;
        m_sel = '0; m_open = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == '0, "R1 valid", 32'(out_valid), 0);
        chk(out_err == '0, "R1 err", 32'(out_err), 0);
        chk(pkt_avail == 1'b0, "R1 avail", 32'(pkt_avail), 0);
        rst_n = 1'b1;

        // R1: default port 0
        word("R1 default port", 2'd0, 1'b1, 1'b1, 32'hA5A5_0001);
        // R3: upper data bits ignored on select
        pick("R3 select", 32'hFFFF_FFF2);
        word("R3 word to port 2", 2'd0, 1'b1, 1'b0, 32'h1111_2222);
        // R4: tx_sel ignored while enabled
        step("R4 sel while enabled", 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0003, 2'd0, 16'h0);
        // R11 idle and R5 hold
        step("R11 idle", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0001, 2'd0, 16'h0);
        step("R11 idle", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0003, 2'd0, 16'h0);
        word("R5 still port 2", 2'd0, 1'b0, 1'b0, 32'h3333_4444);
        // R6: each modulo value on final words
        for (int k = 0; k < 4; k++) begin
            word("R6 eop mask", 2'(k), 1'b1, 1'b1, 32'hC0DE_0000 + 32'(k));
        end
        // R7 and R8: nonzero modulo mid-packet
        pick("R8 select", 32'h0000_0001);
        word("R7 sop", 2'd0, 1'b1, 1'b0, 32'h0101_0101);
        word("R7 R8 bad mod", 2'd2, 1'b0, 1'b0, 32'h0202_0202);
        // R9: restart while open, interleaved ports
        word("R9 restart", 2'd0, 1'b1, 1'b0, 32'h0303_0303);
        pick("R9 select 3", 32'h0000_0003);
        word("R9 sop port 3", 2'd0, 1'b1, 1'b0, 32'h0404_0404);
        pick("R9 select 1", 32'h0000_0001);
        word("R9 eop port 1", 2'd1, 1'b0, 1'b1, 32'h0505_0505);
        word("R9 fresh sop", 2'd0, 1'b1, 1'b1, 32'h0606_0606);
        pick("R9 select 3", 32'h0000_0003);
        word("R9 restart port 3", 2'd0, 1'b1, 1'b1, 32'h0707_0707);
        // R10: polling around the threshold
        for (int a = 0; a < 4; a++) begin
            step("R10 poll", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 2'(a), 16'h8787 ^ 16'(a * 16'h0f0f));
        end
        step("R10 poll", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 2'd0, 16'h0007);
        step("R10 poll", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 2'd0, 16'h0008);

        // R2: random traffic
        for (int i = 0; i < 4000; i++) begin
            logic       en_n, sel, sop, eop;
            logic [1:0] mod;
            en_n = ($urandom % 3) == 0;
            sel  = $urandom % 2;
            sop  = ($urandom % 4) == 0;
            eop  = ($urandom % 4) == 0;
            mod  = (eop || ($urandom % 16) == 0) ? 2'($urandom) : 2'd0;
            step("R2 random", en_n, sel, mod, sop, eop, $urandom, 2'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule